// File: doc/BRIEF.md
# Five-Master Round-Robin Bus Crossbar

This block is a simplified single-transfer interconnect between five bus masters and four slave regions. The masters are indexed 0 to 4: instruction fetch, data/literal load, system, DMA memory side and DMA peripheral side. The slave regions are indexed 0 to 3: code flash, SRAM, peripheral region A and peripheral region B. Region A also covers the peripherals that sit behind the bridges to the slower peripheral buses. Each master's address is decoded against fixed base/size windows. Each master may reach only a fixed subset of regions. A request that falls outside the master's reach, or outside every window, is answered locally with an error and never reaches a slave.

Each slave region has its own arbiter. The arbiter rotates its grant among the masters that request it. Once a grant is issued, it stays with that master until the slave signals ready. A master holds its request, address, write flag and write data until it sees `m_ready` high. The transfer completes at the clock edge that ends that cycle. Slave regions work independently, so different masters can finish transfers on different slaves in the same cycle. The reach of the DMA memory-side master into the peripheral regions is chosen at elaboration time.

Top module: `xbar_top`

## Requirements
- R1: Each slave arbiter grants in rotating order. After reset, master 0 is first in line. After master i completes a transfer on a slave, the next grant for that slave goes to the first requesting master in the order i+1, i+2, ... (modulo 5).
- R2: Masters 0 (instruction fetch) and 1 (data/literal) may reach only slave 0 (flash) and slave 1 (SRAM).
- R3: Master 2 (system) may reach slaves 1, 2 and 3 (SRAM and both peripheral regions) but not slave 0 (flash).
- R4: Master 3 (DMA memory side) may reach slaves 0 and 1. It reaches slaves 2 and 3 only when parameter `DMA_MEM_PERIPH` is 1.
- R5: Master 4 (DMA peripheral side) may reach all four slaves.
- R6: Slave s is hit when `SLV_BASE[s] <= addr < SLV_BASE[s] + SLV_SIZE[s]`. With the defaults, slaves 0..3 are at 0x1000_0000, 0x2000_0000, 0x4000_0000 and 0x5000_0000, each 0x0100_0000 bytes. An address outside every window is answered with an error.
- R7: An unreachable or unmapped request, presented in cycle t, gives `m_err` high with `m_ready` low in cycle t+1. It gives `m_err` and `m_ready` both high in cycle t+2. No slave is selected, and a write carried by such a request leaves the slave unchanged.
- R8: A granted transfer is not preempted. The grant stays on the same master until the slave raises `s_ready`, even if a master with higher rotation priority arrives meanwhile. The rotation pointer moves only when a transfer completes.
- R9: A master that is not granted sees `m_ready` low. A granted transfer completes in the cycle in which the selected slave raises `s_ready`. In that cycle `m_ready` is high, `m_err` is low, and `m_rdata` carries the slave's `s_rdata`. The slave receives the master's address, write flag and write data.
- R10: Different slaves serve different masters in the same cycles without interfering.
- R11: Reset is synchronous and active high. After reset no slave is selected, and `m_ready` and `m_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 5 | Per-master transfer request, held until ready |
| m_addr | input | 5x32 | Per-master byte address |
| m_we | input | 5 | Per-master write flag |
| m_wdata | input | 5x32 | Per-master write data |
| m_rdata | output | 5x32 | Per-master read data, valid with ready |
| m_ready | output | 5 | Per-master transfer completion |
| m_err | output | 5 | Per-master error response |
| s_sel | output | 4 | Per-slave select |
| s_addr | output | 4x32 | Per-slave forwarded address |
| s_we | output | 4 | Per-slave forwarded write flag |
| s_wdata | output | 4x32 | Per-slave forwarded write data |
| s_rdata | input | 4x32 | Per-slave read data |
| s_ready | input | 4 | Per-slave completion |

## Verification
A corrupted rotation pointer shows at the first contended completion: two back-to-back `m_ready` pulses go to masters out of rotation order. A lock register that drops early or sticks shows within a single slave latency, either as a `m_ready` pulse for the later arrival before the first owner's, or as a selected slave whose master never completes. A wrong reach mask or window shows on the first request to that region. The symptom is `m_err` where data was expected, or the reverse, together with `s_sel` activity. An error sequencer in the wrong state shifts or stretches the two-cycle `m_err`/`m_ready` pattern at once.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int NUM_MST = 5;
    localparam int NUM_SLV = 4;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int MIDX_W  = $clog2(NUM_MST);

    localparam int MST_IFETCH  = 0;
    localparam int MST_DATA    = 1;
    localparam int MST_SYS     = 2;
    localparam int MST_DMA_MEM = 3;
    localparam int MST_DMA_PER = 4;

    localparam int SLV_FLASH = 0;
    localparam int SLV_SRAM  = 1;
    localparam int SLV_PER_A = 2;
    localparam int SLV_PER_B = 3;

    typedef logic [NUM_SLV-1:0] slv_mask_t;

    typedef enum logic [1:0] {
        ERR_IDLE  = 2'd0,
        ERR_FIRST = 2'd1,
        ERR_LAST  = 2'd2
    } err_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    // Fixed reach of each master over the slave regions.
    function automatic slv_mask_t reach_of(int m, bit dma_periph);
        slv_mask_t mem_pair;
        slv_mask_t periph;
        mem_pair = (slv_mask_t'(1) << SLV_FLASH) | (slv_mask_t'(1) << SLV_SRAM);
        periph   = (slv_mask_t'(1) << SLV_PER_A) | (slv_mask_t'(1) << SLV_PER_B);
        case (m)
            MST_IFETCH, MST_DATA: return mem_pair;
            MST_SYS:              return periph | (slv_mask_t'(1) << SLV_SRAM);
            MST_DMA_MEM:          return dma_periph ? (mem_pair | periph) : mem_pair;
            MST_DMA_PER:          return mem_pair | periph;
            default:              return '0;
        endcase
    endfunction

endpackage

// File: rtl/xbar_mst_port.sv
module xbar_mst_port
    import xbar_pkg::*;
#(
    parameter logic [NUM_SLV-1:0][ADDR_W-1:0] BASE  = '0,
    parameter logic [NUM_SLV-1:0][ADDR_W-1:0] SIZE  = '0,
    parameter slv_mask_t                      REACH = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output slv_mask_t         route,
    output logic              err,
    output logic              err_done
);

    slv_mask_t  hit;
    logic       legal;
    err_state_e state_q, state_d;

    always_comb begin
        for (int s = 0; s < NUM_SLV; s++) begin
            hit[s] = (addr >= BASE[s]) && ((addr - BASE[s]) < SIZE[s]);
        end
        legal = |(hit & REACH);
        route = (req && state_q == ERR_IDLE) ? (hit & REACH) : '0;
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            ERR_IDLE:  if (req && !legal) state_d = ERR_FIRST;
            ERR_FIRST: state_d = ERR_LAST;
            ERR_LAST:  state_d = ERR_IDLE;
            default:   state_d = ERR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ERR_IDLE;
        else     state_q <= state_d;
    end

    assign err      = (state_q != ERR_IDLE);
    assign err_done = (state_q == ERR_LAST);

    // R7
    err_start_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !legal && !err) |=> (err && !err_done));

    // R7
    err_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !err_done) |=> (err && err_done));

endmodule

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
    parameter int N = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req,
    input  logic                 done,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] gidx
);

    localparam int IW = $clog2(N);

    logic [IW-1:0] last_q;
    logic [IW-1:0] owner_q;
    logic          locked_q;
    logic [N-1:0]  pick;
    logic          found;
    int            cand;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        cand  = 0;
        for (int off = 1; off <= N; off++) begin
            cand = (int'(last_q) + off) % N;
            if (!found && req[cand]) begin
                pick[cand] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    always_comb begin
        if (locked_q) gnt = req[owner_q] ? (N'(1) << owner_q) : '0;
        else          gnt = pick;
        gidx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) gidx = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q   <= IW'(N - 1);
            owner_q  <= '0;
            locked_q <= 1'b0;
        end else if (|gnt) begin
            if (done) begin
                last_q   <= gidx;
                locked_q <= 1'b0;
            end else begin
                owner_q  <= gidx;
                locked_q <= 1'b1;
            end
        end else begin
            locked_q <= 1'b0;
        end
    end

    // R8
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (|gnt && !done) |=> ((gnt == $past(gnt)) || !(|(req & $past(gnt)))));

    // R1
    rr_rotate_chk: assert property (@(posedge clk) disable iff (rst)
        (|gnt && done) |=> (($countones(req) <= 1) || (gnt != $past(gnt))));

endmodule

// File: rtl/xbar_top.sv
module xbar_top
    import xbar_pkg::*;
#(
    parameter logic [NUM_SLV-1:0][ADDR_W-1:0] SLV_BASE = {32'h5000_0000, 32'h4000_0000,
                                                          32'h2000_0000, 32'h1000_0000},
    parameter logic [NUM_SLV-1:0][ADDR_W-1:0] SLV_SIZE = {4{32'h0100_0000}},
    parameter bit                             DMA_MEM_PERIPH = 1'b0
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_MST-1:0]                m_req,
    input  logic [NUM_MST-1:0][ADDR_W-1:0]    m_addr,
    input  logic [NUM_MST-1:0]                m_we,
    input  logic [NUM_MST-1:0][DATA_W-1:0]    m_wdata,
    output logic [NUM_MST-1:0][DATA_W-1:0]    m_rdata,
    output logic [NUM_MST-1:0]                m_ready,
    output logic [NUM_MST-1:0]                m_err,
    output logic [NUM_SLV-1:0]                s_sel,
    output logic [NUM_SLV-1:0][ADDR_W-1:0]    s_addr,
    output logic [NUM_SLV-1:0]                s_we,
    output logic [NUM_SLV-1:0][DATA_W-1:0]    s_wdata,
    input  logic [NUM_SLV-1:0][DATA_W-1:0]    s_rdata,
    input  logic [NUM_SLV-1:0]                s_ready
);

    slv_mask_t          route     [NUM_MST];
    logic               perr      [NUM_MST];
    logic               perr_done [NUM_MST];
    xfer_t              mx        [NUM_MST];
    xfer_t              sx        [NUM_SLV];
    logic [NUM_MST-1:0] sreq      [NUM_SLV];
    logic [NUM_MST-1:0] gnt       [NUM_SLV];
    logic [MIDX_W-1:0]  gidx      [NUM_SLV];
    logic [NUM_MST-1:0] served;

    for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
        xbar_mst_port #(
            .BASE  (SLV_BASE),
            .SIZE  (SLV_SIZE),
            .REACH (reach_of(m, DMA_MEM_PERIPH))
        ) u_port (
            .clk      (clk),
            .rst      (rst),
            .req      (m_req[m]),
            .addr     (m_addr[m]),
            .route    (route[m]),
            .err      (perr[m]),
            .err_done (perr_done[m])
        );

        assign mx[m] = '{addr: m_addr[m], we: m_we[m], wdata: m_wdata[m]};

        // R7
        err_isolate_chk: assert property (@(posedge clk) disable iff (rst)
            m_err[m] |-> !served[m]);
    end

    always_comb begin
        for (int s = 0; s < NUM_SLV; s++) begin
            for (int m = 0; m < NUM_MST; m++) begin
                sreq[s][m] = route[m][s];
            end
        end
    end

    for (genvar s = 0; s < NUM_SLV; s++) begin : g_slv
        xbar_rr_arb #(.N(NUM_MST)) u_arb (
            .clk  (clk),
            .rst  (rst),
            .req  (sreq[s]),
            .done (s_ready[s]),
            .gnt  (gnt[s]),
            .gidx (gidx[s])
        );
    end

    // Forward path: one granted master per slave.
    always_comb begin
        for (int s = 0; s < NUM_SLV; s++) begin
            sx[s] = mx[gidx[s]];
            if (!(|gnt[s])) sx[s] = '0;
            s_sel[s]   = |gnt[s];
            s_addr[s]  = sx[s].addr;
            s_we[s]    = sx[s].we;
            s_wdata[s] = sx[s].wdata;
        end
    end

    // Return path: a master is served by at most one slave.
    always_comb begin
        for (int m = 0; m < NUM_MST; m++) begin
            served[m]  = 1'b0;
            m_rdata[m] = '0;
            m_ready[m] = perr_done[m];
            m_err[m]   = perr[m];
            for (int s = 0; s < NUM_SLV; s++) begin
                if (gnt[s][m]) begin
                    served[m]  = 1'b1;
                    m_rdata[m] = s_rdata[s];
                    m_ready[m] = m_ready[m] | s_ready[s];
                end
            end
        end
    end

endmodule

// File: tb/tb_xbar_top.sv
module tb_xbar_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [4:0]       m_req   = '0;
    logic [4:0][31:0] m_addr  = '0;
    logic [4:0]       m_we    = '0;
    logic [4:0][31:0] m_wdata = '0;
    logic [4:0][31:0] m_rdata;
    logic [4:0]       m_ready, m_err;
    logic [3:0]       s_sel, s_we;
    logic [3:0][31:0] s_addr, s_wdata, s_rdata;
    logic [3:0]       s_ready;

    logic [4:0][31:0] o_rdata;
    logic [4:0]       o_ready, o_err;
    logic [3:0]       o_sel, o_we;
    logic [3:0][31:0] o_addr, o_wdata;

    xbar_top dut (
        .clk(clk), .rst(rst), .m_req(m_req), .m_addr(m_addr), .m_we(m_we),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready), .m_err(m_err),
        .s_sel(s_sel), .s_addr(s_addr), .s_we(s_we), .s_wdata(s_wdata),
        .s_rdata(s_rdata), .s_ready(s_ready)
    );

    xbar_top #(.DMA_MEM_PERIPH(1'b1)) dut_opt (
        .clk(clk), .rst(rst), .m_req(m_req), .m_addr(m_addr), .m_we(m_we),
        .m_wdata(m_wdata), .m_rdata(o_rdata), .m_ready(o_ready), .m_err(o_err),
        .s_sel(o_sel), .s_addr(o_addr), .s_we(o_we), .s_wdata(o_wdata),
        .s_rdata('0), .s_ready(4'hF)
    );

    localparam logic [31:0] BASES [5] = '{32'h1000_0000, 32'h2000_0000, 32'h4000_0000,
                                          32'h5000_0000, 32'h6000_0000};
    localparam int LAT [4] = '{2, 0, 1, 3};

    // Slave models: small memories with fixed wait counts.
    logic [31:0] mem  [4][16];
    int          wcnt [4];

    function automatic logic [31:0] initval(int s, int i);
        return 32'hA000_0000 + 32'(s * 256 + i);
    endfunction

    always_comb begin
        for (int s = 0; s < 4; s++) begin
            s_ready[s] = s_sel[s] && (wcnt[s] == LAT[s]);
            s_rdata[s] = mem[s][s_addr[s][5:2]];
        end
    end

    always @(posedge clk) begin
        for (int s = 0; s < 4; s++) begin
            if (rst) begin
                wcnt[s] <= 0;
                for (int i = 0; i < 16; i++) mem[s][i] <= initval(s, i);
            end else begin
                if (s_sel[s] && !s_ready[s]) wcnt[s] <= wcnt[s] + 1;
                else                         wcnt[s] <= 0;
                if (s_sel[s] && s_ready[s] && s_we[s]) mem[s][s_addr[s][5:2]] <= s_wdata[s];
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit may_reach(int m, int s, bit opt);
        if (s >= 4) return 1'b0;
        case (m)
            0, 1:    return s < 2;
            2:       return s != 0;
            3:       return (s < 2) || opt;
            default: return 1'b1;
        endcase
    endfunction

    function automatic string reach_tag(int m, int s);
        if (s >= 4) return "R6";
        case (m)
            0, 1:    return "R2";
            2:       return "R3";
            3:       return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic do_xfer(input int m, input logic [31:0] a, input logic we,
                           input logic [31:0] wd, output logic [31:0] rd,
                           output logic er, output int cyc, output logic sel_seen,
                           output logic opt_r0);
        @(negedge clk);
        m_addr[m]  = a;
        m_we[m]    = we;
        m_wdata[m] = wd;
        m_req[m]   = 1'b1;
        cyc        = 0;
        sel_seen   = 1'b0;
        opt_r0     = 1'b0;
        while (1) begin
            #1;
            if (cyc == 0) opt_r0 = o_ready[m];
            sel_seen = sel_seen | (|s_sel);
            if (m_ready[m] || cyc > 50) break;
            @(negedge clk);
            cyc++;
        end
        rd = m_rdata[m];
        er = m_err[m];
        @(posedge clk);
        #1 m_req[m] = 1'b0;
    endtask

    task automatic do_reset();
        m_req = '0;
        rst   = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    logic done_flag = 1'b0;

    initial begin
        repeat (50000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, a, wd;
        logic        er, sel, o0;
        int          cyc;

        do_reset();
        @(negedge clk);
        #1;
        // R11 reset state
        chk(m_ready == 5'b0, "R11", "m_ready after reset", 32'(m_ready), 32'h0);
        chk(m_err == 5'b0,   "R11", "m_err after reset",   32'(m_err),   32'h0);
        chk(s_sel == 4'b0,   "R11", "s_sel after reset",   32'(s_sel),   32'h0);

        // Reach sweep over every master and every region plus an unmapped window
        for (int m = 0; m < 5; m++) begin
            for (int s = 0; s < 5; s++) begin
                int  idx;
                bit  ok;
                idx = (m * 3 + s) % 16;
                a   = BASES[s] + 32'(idx * 4);
                wd  = 32'hC0DE_0000 | 32'(m << 8) | 32'(s);
                ok  = may_reach(m, s, 1'b0);
                do_xfer(m, a, 1'b1, wd, rd, er, cyc, sel, o0);
                chk(er == !ok, reach_tag(m, s), "error flag", 32'(er), 32'(!ok));
                chk(o0 == may_reach(m, s, 1'b1), (m == 3) ? "R4" : reach_tag(m, s),
                    "option build ready", 32'(o0), 32'(may_reach(m, s, 1'b1)));
                if (ok) begin
                    chk(cyc == LAT[s], "R9", "cycles to ready", 32'(cyc), 32'(LAT[s]));
                    do_xfer(m, a, 1'b0, 32'h0, rd, er, cyc, sel, o0);
                    chk(rd == wd && !er, "R9", "read back", rd, wd);
                end else begin
                    chk(cyc == 2, "R7", "error response length", 32'(cyc), 32'd2);
                    chk(!sel, "R7", "slave selected on error", 32'(sel), 32'h0);
                    if (s < 4) begin
                        do_xfer(4, a, 1'b0, 32'h0, rd, er, cyc, sel, o0);
                        chk(rd == initval(s, idx), "R7", "rejected write left slave",
                            rd, initval(s, idx));
                    end
                end
            end
        end

        // R1 rotation, all five masters on SRAM (zero wait)
        do_reset();
        @(negedge clk);
        for (int m = 0; m < 5; m++) begin
            m_addr[m] = BASES[1] + 32'(m * 4);
            m_we[m]   = 1'b0;
        end
        m_req = 5'h1F;
        for (int k = 0; k < 10; k++) begin
            #1;
            chk(m_ready == (5'b1 << (k % 5)), "R1", "sram rotation", 32'(m_ready),
                32'(5'b1 << (k % 5)));
            @(negedge clk);
        end
        m_req = '0;

        // R1 and R9: masters 0,1,3 on flash (two waits)
        do_reset();
        @(negedge clk);
        for (int m = 0; m < 5; m++) begin
            m_addr[m] = BASES[0] + 32'(m * 4);
            m_we[m]   = 1'b0;
        end
        m_req = 5'b01011;
        for (int c = 0; c < 9; c++) begin
            logic [4:0] exp;
            int         order [3];
            order = '{0, 1, 3};
            exp   = (c % 3 == 2) ? (5'b1 << order[c / 3]) : 5'b0;
            #1;
            chk(m_ready == exp, "R1", "flash rotation with waits", 32'(m_ready), 32'(exp));
            chk(s_sel[0], "R9", "flash stays selected", 32'(s_sel[0]), 32'h1);
            @(negedge clk);
        end
        m_req = '0;

        // R8: master 1 holds flash while master 0 arrives a cycle later
        do_reset();
        begin
            logic [31:0] rd1, rd0;
            logic        er1, er0, sl1, sl0, oa, ob;
            int          c1, c0;
            fork
                do_xfer(1, BASES[0] + 32'h10, 1'b0, 32'h0, rd1, er1, c1, sl1, oa);
                begin
                    @(negedge clk);
                    do_xfer(0, BASES[0] + 32'h14, 1'b0, 32'h0, rd0, er0, c0, sl0, ob);
                end
            join
            chk(c1 == 2, "R8", "owner completes first", 32'(c1), 32'd2);
            chk(c0 == 4, "R8", "late arrival waits for owner", 32'(c0), 32'd4);
        end

        // R10: three masters on three slaves at once
        do_reset();
        begin
            logic [31:0] ra, rb, rc;
            logic        ea, eb, ec, sa, sb, sc, oa, ob, oc;
            int          ca, cb, cc;
            fork
                do_xfer(0, BASES[0] + 32'h8, 1'b0, 32'h0, ra, ea, ca, sa, oa);
                do_xfer(2, BASES[2] + 32'h8, 1'b0, 32'h0, rb, eb, cb, sb, ob);
                do_xfer(3, BASES[1] + 32'h8, 1'b0, 32'h0, rc, ec, cc, sc, oc);
            join
            chk(ca == 2 && ra == initval(0, 2), "R10", "flash in parallel", ra, initval(0, 2));
            chk(cb == 1 && rb == initval(2, 2), "R10", "periph A in parallel", rb, initval(2, 2));
            chk(cc == 0 && rc == initval(1, 2), "R10", "sram in parallel", rc, initval(1, 2));
        end

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule